// File: doc/BRIEF.md
# Carry-Save Diminished-1 Fermat Transform Butterfly

This block is one radix-2 butterfly for a Fermat number transform over the ring of integers modulo 2^n+1. It never resolves a carry. Each operand arrives as two n-bit vectors, and each vector is a diminished-1 number, so a vector v stands for the residue v+1. The operand is the modular sum of its two vectors. The block scales the second operand by 2^t and forms the sum and the difference. Each result again leaves as a pair of vectors, so a chain of butterflies can pass redundant operands from one stage to the next. The carry chain is resolved only once, at the end of the chain.

Each vector of the second operand goes through a rotate-and-invert network that multiplies it by 2^t. The difference branch complements the two scaled vectors, because that is negation in diminished-1 form. Each branch then reduces its four vectors to two in a modular 4-to-2 compressor. The compressor is built from two carry-save levels. At each level the carry leaving the top bit is inverted and fed back into bit 0. An optional output register is chosen by a parameter.

Top module: `fnt_bfly_cs`

## Requirements
- R1: An operand given as the vector pair (v0, v1) has the value (v0 + v1 + 2) mod 2^n+1. Every n-bit pattern is a legal vector, and pairs with the same total give the same results.
- R2: The output pair (m_a, m_b) has the value (K + L·2^t) mod 2^n+1, where K comes from (k_a, k_b), L comes from (l_a, l_b) and t is shift_exp.
- R3: The output pair (n_a, n_b) has the value (K − L·2^t) mod 2^n+1.
- R4: With shift_exp = 0 the two results are the plain modular sum K+L and the plain modular difference K−L.
- R5: Every shift_exp from 0 to n−1 scales correctly, up to n−1 where all but one bit of each scaled vector wrap around inverted. A single vector d scaled by 2^t gives a vector q with (q+1) ≡ (d+1)·2^t.
- R6: All-ones vectors, which stand for 2^n ≡ −1, are handled, and a result whose residue is zero is carried correctly as a pair.
- R7: With the output register selected (the default), results appear at the outputs on the first rising clock edge after the inputs are applied. The outputs hold their old values until that edge.
- R8: An active-low asynchronous reset forces all four output vectors to zero.
- R9: The two results satisfy (M + N) mod 2^n+1 = 2K mod 2^n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| shift_exp | input | $clog2(WIDTH) | Exponent t of the twiddle factor 2^t |
| k_a | input | WIDTH | First vector of operand K |
| k_b | input | WIDTH | Second vector of operand K |
| l_a | input | WIDTH | First vector of operand L |
| l_b | input | WIDTH | Second vector of operand L |
| m_a | output | WIDTH | First vector of the sum result M |
| m_b | output | WIDTH | Second vector of the sum result M |
| n_a | output | WIDTH | First vector of the difference result N |
| n_b | output | WIDTH | Second vector of the difference result N |

## Verification
Both result pairs have one cycle of latency. The bench changes the inputs on a falling edge, and the rising edge after that captures the results. The bench reads them at the next falling edge, where it resolves each pair to its residue and compares it with integer modular arithmetic. For the hold check, the bench applies new inputs and looks a quarter period later, before the capturing edge, when the outputs must still carry the previous residues. The reset check reads the outputs while the reset is low, because the reset clears them at once without waiting for a clock.

// File: rtl/fnt_bfly_pkg.sv
package fnt_bfly_pkg;

  // Selects whether the butterfly results pass through an output register.
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

endpackage

// File: rtl/fnt_pow2_scale.sv
// Multiplies one diminished-1 vector by 2^sh modulo 2^W+1.
// Stage s rotates the vector left by 2^s and inverts the bits that wrap.
module fnt_pow2_scale #(
  parameter int WIDTH = 8,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   sh,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [SHW+1];

  assign stg[0] = din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int AMT = 1 << s;
    logic [WIDTH-1:0] rot;
    assign rot = {stg[s][WIDTH-1-AMT:0], ~stg[s][WIDTH-1:WIDTH-AMT]};
    assign stg[s+1] = sh[s] ? rot : stg[s];
  end

  assign dout = stg[SHW];

endmodule

// File: rtl/fnt_mod_csa.sv
// One carry-save level modulo 2^W+1 in diminished-1 form.
// The carry out of the top bit is inverted and fed back into bit 0.
// The output pair then satisfies s + c == a + b + c_in + 1 (mod 2^W+1).
module fnt_mod_csa #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] car
);

  logic [WIDTH-1:0] maj;

  assign sum = a ^ b ^ c;
  assign maj = (a & b) | (a & c) | (b & c);
  assign car = {maj[WIDTH-2:0], ~maj[WIDTH-1]};

endmodule

// File: rtl/fnt_mod_compress42.sv
// Modular 4-to-2 compressor: four diminished-1 vectors in, one pair out.
// The pair's residue equals the sum of the four inputs' residues.
module fnt_mod_compress42 #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] in0,
  input  logic [WIDTH-1:0] in1,
  input  logic [WIDTH-1:0] in2,
  input  logic [WIDTH-1:0] in3,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] car
);

  logic [WIDTH-1:0] lvl1_sum;
  logic [WIDTH-1:0] lvl1_car;

  fnt_mod_csa #(.WIDTH(WIDTH)) u_lvl1 (
    .a   (in0),
    .b   (in1),
    .c   (in2),
    .sum (lvl1_sum),
    .car (lvl1_car)
  );

  fnt_mod_csa #(.WIDTH(WIDTH)) u_lvl2 (
    .a   (lvl1_sum),
    .b   (lvl1_car),
    .c   (in3),
    .sum (sum),
    .car (car)
  );

endmodule

// File: rtl/fnt_bfly_cs.sv
// Radix-2 butterfly on redundant diminished-1 operands:
//   M = K + L*2^t,  N = K - L*2^t  (mod 2^WIDTH+1)
module fnt_bfly_cs
  import fnt_bfly_pkg::*;
#(
  parameter int        WIDTH    = 8,
  parameter out_mode_e OUT_MODE = OUT_REG,
  localparam int       SHW      = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SHW-1:0]   shift_exp,
  input  logic [WIDTH-1:0] k_a,
  input  logic [WIDTH-1:0] k_b,
  input  logic [WIDTH-1:0] l_a,
  input  logic [WIDTH-1:0] l_b,
  output logic [WIDTH-1:0] m_a,
  output logic [WIDTH-1:0] m_b,
  output logic [WIDTH-1:0] n_a,
  output logic [WIDTH-1:0] n_b
);

  // Named internal results, brought out for the checker.
  logic [WIDTH-1:0] l_a_scaled;
  logic [WIDTH-1:0] l_b_scaled;
  logic [WIDTH-1:0] l_a_neg;
  logic [WIDTH-1:0] l_b_neg;
  logic [WIDTH-1:0] m_sum_c;
  logic [WIDTH-1:0] m_car_c;
  logic [WIDTH-1:0] n_sum_c;
  logic [WIDTH-1:0] n_car_c;

  fnt_pow2_scale #(.WIDTH(WIDTH)) u_scale_a (
    .din  (l_a),
    .sh   (shift_exp),
    .dout (l_a_scaled)
  );

  fnt_pow2_scale #(.WIDTH(WIDTH)) u_scale_b (
    .din  (l_b),
    .sh   (shift_exp),
    .dout (l_b_scaled)
  );

  // Negation in diminished-1 form is the bitwise complement.
  assign l_a_neg = ~l_a_scaled;
  assign l_b_neg = ~l_b_scaled;

  fnt_mod_compress42 #(.WIDTH(WIDTH)) u_cmp_sum (
    .in0 (k_a),
    .in1 (k_b),
    .in2 (l_a_scaled),
    .in3 (l_b_scaled),
    .sum (m_sum_c),
    .car (m_car_c)
  );

  fnt_mod_compress42 #(.WIDTH(WIDTH)) u_cmp_dif (
    .in0 (k_a),
    .in1 (k_b),
    .in2 (l_a_neg),
    .in3 (l_b_neg),
    .sum (n_sum_c),
    .car (n_car_c)
  );

  if (OUT_MODE == OUT_REG) begin : g_reg_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_a <= '0;
        m_b <= '0;
        n_a <= '0;
        n_b <= '0;
      end else begin
        m_a <= m_sum_c;
        m_b <= m_car_c;
        n_a <= n_sum_c;
        n_b <= n_car_c;
      end
    end
  end else begin : g_comb_out
    assign m_a = m_sum_c;
    assign m_b = m_car_c;
    assign n_a = n_sum_c;
    assign n_b = n_car_c;
  end

endmodule

// File: rtl/fnt_bfly_cs_chk.sv
module fnt_bfly_cs_chk
  import fnt_bfly_pkg::*;
#(
  parameter int        WIDTH    = 8,
  parameter out_mode_e OUT_MODE = OUT_REG,
  localparam int       SHW      = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SHW-1:0]   shift_exp,
  input logic [WIDTH-1:0] k_a,
  input logic [WIDTH-1:0] k_b,
  input logic [WIDTH-1:0] l_a,
  input logic [WIDTH-1:0] l_b,
  input logic [WIDTH-1:0] m_a,
  input logic [WIDTH-1:0] m_b,
  input logic [WIDTH-1:0] n_a,
  input logic [WIDTH-1:0] n_b,
  input logic [WIDTH-1:0] l_a_scaled,
  input logic [WIDTH-1:0] l_b_scaled,
  input logic [WIDTH-1:0] m_sum_c,
  input logic [WIDTH-1:0] m_car_c,
  input logic [WIDTH-1:0] n_sum_c,
  input logic [WIDTH-1:0] n_car_c
);

  localparam longint unsigned MOD = (64'd1 << WIDTH) + 64'd1;

  function automatic longint unsigned pair_val(logic [WIDTH-1:0] v0, logic [WIDTH-1:0] v1);
    return (longint'(v0) + longint'(v1) + 64'd2) % MOD;
  endfunction

  function automatic longint unsigned one_val(logic [WIDTH-1:0] v);
    return (longint'(v) + 64'd1) % MOD;
  endfunction

  function automatic longint unsigned times_pow2(longint unsigned x, logic [SHW-1:0] t);
    return (x << t) % MOD;
  endfunction

  longint unsigned k_ref, ls_ref, m_ref, n_ref;

  always_comb begin
    k_ref  = pair_val(k_a, k_b);
    ls_ref = times_pow2(pair_val(l_a, l_b), shift_exp);
    m_ref  = (k_ref + ls_ref) % MOD;
    n_ref  = (k_ref + MOD - ls_ref) % MOD;
  end

  // R5: each scaling network multiplies its vector's residue by 2^t
  assert_scale_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    one_val(l_a_scaled) == times_pow2(one_val(l_a), shift_exp));
  assert_scale_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    one_val(l_b_scaled) == times_pow2(one_val(l_b), shift_exp));

  // R2: the sum compressor pair resolves to K + L*2^t
  assert_sum_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_val(m_sum_c, m_car_c) == m_ref);

  // R3: the difference compressor pair resolves to K - L*2^t
  assert_dif_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_val(n_sum_c, n_car_c) == n_ref);

  if (OUT_MODE == OUT_REG) begin : g_reg_checks
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
    end

    // R7: registered results match the inputs of the previous edge
    assert_latency_m_R7: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> pair_val(m_a, m_b) == $past(m_ref));
    assert_latency_n_R7: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> pair_val(n_a, n_b) == $past(n_ref));

    // R9: sum and difference add up to twice K
    assert_sum_dif_R9: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((pair_val(m_a, m_b) + pair_val(n_a, n_b)) % MOD) == ((2 * $past(k_ref)) % MOD));

    // R8: a reset held at an edge leaves all vectors at zero
    assert_reset_zero_R8: assert property (@(posedge clk)
      !rst_n |=> (m_a == '0 && m_b == '0 && n_a == '0 && n_b == '0));
  end

endmodule

bind fnt_bfly_cs fnt_bfly_cs_chk #(.WIDTH(WIDTH), .OUT_MODE(OUT_MODE)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_exp  (shift_exp),
  .k_a        (k_a),
  .k_b        (k_b),
  .l_a        (l_a),
  .l_b        (l_b),
  .m_a        (m_a),
  .m_b        (m_b),
  .n_a        (n_a),
  .n_b        (n_b),
  .l_a_scaled (l_a_scaled),
  .l_b_scaled (l_b_scaled),
  .m_sum_c    (m_sum_c),
  .m_car_c    (m_car_c),
  .n_sum_c    (n_sum_c),
  .n_car_c    (n_car_c)
);

// File: tb/fnt_bfly_cs_tb_top.sv
module fnt_bfly_cs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int SW  = 3;
  localparam int MOD = 257;
  localparam int NVEC = 13;

  // {t, k_a, k_b, l_a, l_b}
  localparam logic [SW+4*W-1:0] VEC [NVEC] = '{
    {3'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    {3'd0, 8'hff, 8'hff, 8'hff, 8'hff},
    {3'd7, 8'h12, 8'h34, 8'h56, 8'h78},
    {3'd7, 8'hff, 8'h00, 8'hff, 8'h00},
    {3'd1, 8'h80, 8'h7f, 8'h01, 8'hfe},
    {3'd3, 8'haa, 8'h55, 8'hc3, 8'h3c},
    {3'd4, 8'h01, 8'h02, 8'h03, 8'h04},
    {3'd5, 8'hfe, 8'hfe, 8'h00, 8'h01},
    {3'd6, 8'h7f, 8'h80, 8'h80, 8'h7f},
    {3'd2, 8'h10, 8'h20, 8'h30, 8'h40},
    {3'd7, 8'hff, 8'hff, 8'hff, 8'hff},
    {3'd0, 8'hff, 8'hfe, 8'h00, 8'h00},
    {3'd0, 8'h00, 8'h00, 8'hfd, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] shift_exp = '0;
  logic [W-1:0]  k_a = '0, k_b = '0, l_a = '0, l_b = '0;
  logic [W-1:0]  m_a, m_b, n_a, n_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fnt_bfly_cs dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_exp (shift_exp),
    .k_a       (k_a),
    .k_b       (k_b),
    .l_a       (l_a),
    .l_b       (l_b),
    .m_a       (m_a),
    .m_b       (m_b),
    .n_a       (n_a),
    .n_b       (n_b)
  );

  // R1: residue of a vector pair
  function automatic int res(logic [W-1:0] v0, logic [W-1:0] v1);
    return (int'(v0) + int'(v1) + 2) % MOD;
  endfunction

  function automatic int exp_m(int t, logic [W-1:0] ka, logic [W-1:0] kb,
                               logic [W-1:0] la, logic [W-1:0] lb);
    return (res(ka, kb) + ((res(la, lb) << t) % MOD)) % MOD;
  endfunction

  function automatic int exp_n(int t, logic [W-1:0] ka, logic [W-1:0] kb,
                               logic [W-1:0] la, logic [W-1:0] lb);
    return (res(ka, kb) + MOD - ((res(la, lb) << t) % MOD)) % MOD;
  endfunction

  task automatic check(string tag, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", tag, got, expv);
    end
  endtask

  task automatic drive(int t, logic [W-1:0] ka, logic [W-1:0] kb,
                       logic [W-1:0] la, logic [W-1:0] lb);
    shift_exp = SW'(t);
    k_a = ka; k_b = kb; l_a = la; l_b = lb;
  endtask

  // Drive on a falling edge, result captured at the next rising edge,
  // read at the falling edge after it.
  task automatic apply(int t, logic [W-1:0] ka, logic [W-1:0] kb,
                       logic [W-1:0] la, logic [W-1:0] lb,
                       string tag_m, string tag_n);
    @(negedge clk);
    drive(t, ka, kb, la, lb);
    @(negedge clk);
    check(tag_m, res(m_a, m_b), exp_m(t, ka, kb, la, lb));
    check(tag_n, res(n_a, n_b), exp_n(t, ka, kb, la, lb));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8: outputs are zero while reset is held
    repeat (2) @(negedge clk);
    check("R8 reset m_a", int'(m_a), 0);
    check("R8 reset m_b", int'(m_b), 0);
    check("R8 reset n_a", int'(n_a), 0);
    check("R8 reset n_b", int'(n_b), 0);
    rst_n = 1'b1;

    // Table walk: R2 sum, R3 difference
    for (int i = 0; i < NVEC; i++) begin
      logic [SW+4*W-1:0] v;
      v = VEC[i];
      apply(int'(v[SW+4*W-1:4*W]), v[4*W-1:3*W], v[3*W-1:2*W], v[2*W-1:W], v[W-1:0],
            "R2 table M", "R3 table N");
    end

    // R4: t=0 is the plain sum and difference
    apply(0, 8'h05, 8'h09, 8'h20, 8'h01, "R4 t0 sum", "R4 t0 diff");
    check("R4 t0 sum literal", res(m_a, m_b), (16 + 35) % MOD);
    check("R4 t0 diff literal", res(n_a, n_b), (16 + MOD - 35) % MOD);

    // R5: largest shift, then every shift with random vectors
    apply(W - 1, 8'h00, 8'h00, 8'h7f, 8'h00, "R5 tmax M", "R5 tmax N");
    for (int t = 0; t < W; t++) begin
      for (int j = 0; j < 8; j++) begin
        apply(t, W'($urandom), W'($urandom), W'($urandom), W'($urandom), "R5 sweep M", "R5 sweep N");
      end
    end

    // R6: zero residue result and all-ones vectors
    apply(0, 8'h00, 8'h00, 8'hfd, 8'h00, "R6 zero M", "R6 zero N");
    check("R6 zero residue", res(m_a, m_b), 0);
    apply(3, 8'hff, 8'hff, 8'hff, 8'hff, "R6 ones M", "R6 ones N");

    // R1: same totals split differently give the same residues
    apply(2, 8'h10, 8'h20, 8'h40, 8'h08, "R1 split a M", "R1 split a N");
    begin
      int m_first, n_first;
      m_first = res(m_a, m_b);
      n_first = res(n_a, n_b);
      apply(2, 8'h30, 8'h00, 8'h00, 8'h48, "R1 split b M", "R1 split b N");
      check("R1 split same M", res(m_a, m_b), m_first);
      check("R1 split same N", res(n_a, n_b), n_first);
    end

    // R9: sum plus difference equals twice K
    apply(6, 8'hc1, 8'h3e, 8'h9a, 8'h11, "R9 M", "R9 N");
    check("R9 identity", (res(m_a, m_b) + res(n_a, n_b)) % MOD,
          (2 * res(8'hc1, 8'h3e)) % MOD);

    // R7: outputs hold until the capturing edge
    apply(1, 8'h01, 8'h01, 8'h01, 8'h01, "R7 first M", "R7 first N");
    @(negedge clk);
    drive(4, 8'hf0, 8'h0f, 8'h33, 8'hcc);
    #(CLK_PERIOD/4);
    check("R7 hold M", res(m_a, m_b), exp_m(1, 8'h01, 8'h01, 8'h01, 8'h01));
    check("R7 hold N", res(n_a, n_b), exp_n(1, 8'h01, 8'h01, 8'h01, 8'h01));
    @(negedge clk);
    check("R7 update M", res(m_a, m_b), exp_m(4, 8'hf0, 8'h0f, 8'h33, 8'hcc));
    check("R7 update N", res(n_a, n_b), exp_n(4, 8'hf0, 8'h0f, 8'h33, 8'hcc));

    // R8: asynchronous reset mid-run clears at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async m_a", int'(m_a), 0);
    check("R8 async m_b", int'(m_b), 0);
    check("R8 async n_a", int'(n_a), 0);
    check("R8 async n_b", int'(n_b), 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(5, 8'h44, 8'h22, 8'h11, 8'h88, "R2 after reset", "R3 after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule